// File: doc/BRIEF.md
# Fractional Divider Synthesizer Channel

This block is the digital model of one channel of a fractional frequency synthesizer. It runs on a fast tick clock, where 32 ticks make one VCO period. A phase-step accumulator stretches a base period of `32 + coarse` ticks by one tick whenever the 15-bit fine accumulator overflows. This gives an average base period of `(32 + coarse) + fine/2^15` ticks.

The base period feeds two further stages. The first is a binary post divider by `2^expo`. The second is a selectable divide by 3. The resulting output rate is `f_tick × 2^15 / ((2^15 × (32 + coarse) + fine) × 2^expo × ns)`, where `ns` is 3 or 1. This is the same as `fin × 32 × 2^20 / ((2^20 × (32+coarse) + 32 × fine) × 2^expo × ns)` with `f_tick = 32 × fin`.

The channel gives two outputs:
- A one-tick enable pulse at the end of each output period.
- A square wave that toggles on each pulse.

New settings on the inputs are taken only at a base-period boundary, so a partial period is never produced. Standby, reset and the all-zero "no rate programmed" setting each hold the channel stopped and cleared.

Top module: `fsyn_channel`

## Requirements
- R1: Each base period lasts `32 + coarse` ticks, plus one tick when adding `fine` to the 15-bit accumulator carries out. With a 15-bit `fine`, the mean base period is `32 + coarse + fine/32768` ticks, and any run of n consecutive base periods is within one tick of n times that mean.
- R2: The binary post divider passes one base period end in every `2^expo`, for `expo` 0 to 8. Values of `expo` above 8 act as 8.
- R3: When `bypass3` is 1, the divide-by-3 stage is bypassed (ns = 1). When `bypass3` is 0, the stage passes one pulse in three (ns = 3).
- R4: The spacing of `out_pulse` over several output periods matches the rate formula within one tick, for any mix of coarse, fine, expo and bypass3.
- R5: A change to coarse, fine, expo or bypass3 made during a base period does not alter that period. It takes effect from the next base-period boundary.
- R6: While `standby` is 1, `out_pulse` and `out_sq` are 0 and all internal counters and the accumulator are cleared.
- R7: While `rst` is 1 (synchronous, active high), `out_pulse` and `out_sq` are 0 and all state is cleared. After release, the first output period starts with the accumulator at 0.
- R8: When coarse, fine and expo are all 0, the channel is treated as unprogrammed and produces no output pulse.
- R9: `out_pulse` is high for exactly one tick per output period. On every pulse, `out_sq` toggles. The first pulse after a clear sets `out_sq` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock (32 ticks per VCO period) |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Stops and clears the channel while high |
| coarse | input | 5 | Integer period extension, 0 to 31 |
| fine | input | 15 | Fractional phase step, 0 to 32767 |
| expo | input | 4 | Post-divider exponent, 0 to 8 (larger acts as 8) |
| bypass3 | input | 1 | 1 = no divide by 3, 0 = divide by 3 |
| out_pulse | output | 1 | One-tick enable at the end of each output period |
| out_sq | output | 1 | Square output, toggles on each pulse |

## Verification
The assertions assume that the setting inputs change only between clock edges and that `standby` and `rst` are plain levels. From this they expect the following:
- Any output pulse is at least 32 ticks after the previous one.
- A pulse never lasts two ticks.
- Standby or the all-zero setting silences the outputs from the next tick.

The stimulus loads each random or directed setting while reset is held, or changes it in mid-period only in the boundary test. Random cases draw coarse and fine over their full ranges. They keep expo at 2 or less so that several output periods fit in the run. Separate directed cases cover the largest divides and the clamped exponent.

// File: rtl/fsyn_pkg.sv
package fsyn_pkg;
  localparam int unsigned BASE_TICKS_DEF = 32;
  localparam int unsigned COARSE_W_DEF   = 5;
  localparam int unsigned FINE_W_DEF     = 15;
  localparam int unsigned EXP_W_DEF      = 4;
  localparam int unsigned EXP_MAX_DEF    = 8;

  // Width needed to hold base + max coarse + carry tick
  function automatic int unsigned len_width(input int unsigned base, input int unsigned cw);
    return $clog2(base + (1 << cw) + 1);
  endfunction
endpackage

// File: rtl/fsyn_phase_acc.sv
module fsyn_phase_acc
  import fsyn_pkg::*;
#(
  parameter int unsigned BASE_TICKS = BASE_TICKS_DEF,
  parameter int unsigned COARSE_W   = COARSE_W_DEF,
  parameter int unsigned FINE_W     = FINE_W_DEF,
  parameter int unsigned EXP_W      = EXP_W_DEF,
  parameter int unsigned EXP_MAX    = EXP_MAX_DEF
) (
  input  logic                clk,
  input  logic                clr,
  input  logic [COARSE_W-1:0] coarse,
  input  logic [FINE_W-1:0]   fine,
  input  logic [EXP_W-1:0]    expo,
  input  logic                bypass3,
  output logic                base_tick,
  output logic [EXP_W-1:0]    expo_act,
  output logic                bypass_act
);
  localparam int unsigned LEN_W = len_width(BASE_TICKS, COARSE_W);

  logic [LEN_W-1:0]  cnt_q, len_q, len_next;
  logic [FINE_W-1:0] acc_q;
  logic [FINE_W:0]   sum;
  logic              running_q, at_end, start;
  logic [EXP_W-1:0]  expo_sat;

  assign sum      = {1'b0, acc_q} + {1'b0, fine};
  assign len_next = LEN_W'(BASE_TICKS) + LEN_W'(coarse) + LEN_W'(sum[FINE_W]);
  assign at_end   = running_q && (cnt_q == len_q - LEN_W'(1));
  assign start    = !running_q || at_end;
  assign expo_sat = (expo > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : expo;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q      <= '0;
      len_q      <= '0;
      acc_q      <= '0;
      running_q  <= 1'b0;
      base_tick  <= 1'b0;
      expo_act   <= '0;
      bypass_act <= 1'b1;
    end else begin
      base_tick <= at_end;
      if (start) begin
        cnt_q      <= '0;
        len_q      <= len_next;
        acc_q      <= sum[FINE_W-1:0];
        running_q  <= 1'b1;
        expo_act   <= expo_sat;
        bypass_act <= bypass3;
      end else begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/fsyn_bin_div.sv
module fsyn_bin_div #(
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned EXP_MAX = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             tick_in,
  input  logic [EXP_W-1:0] expo,
  output logic             tick_out
);
  localparam int unsigned CW = (EXP_MAX > 0) ? EXP_MAX : 1;

  logic [CW:0]   one_sh;
  logic [CW-1:0] lim, cnt_q;

  assign one_sh = (CW+1)'(1) << expo;
  assign lim    = CW'(one_sh - (CW+1)'(1));

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q    <= '0;
      tick_out <= 1'b0;
    end else begin
      tick_out <= 1'b0;
      if (tick_in) begin
        if (cnt_q >= lim) begin
          cnt_q    <= '0;
          tick_out <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fsyn_div3.sv
module fsyn_div3 (
  input  logic clk,
  input  logic clr,
  input  logic tick_in,
  input  logic bypass,
  output logic tick_out
);
  logic [1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q    <= '0;
      tick_out <= 1'b0;
    end else begin
      tick_out <= 1'b0;
      if (tick_in) begin
        if (bypass || cnt_q == 2'd2) begin
          cnt_q    <= '0;
          tick_out <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/fsyn_channel.sv
module fsyn_channel
  import fsyn_pkg::*;
#(
  parameter int unsigned BASE_TICKS = BASE_TICKS_DEF,
  parameter int unsigned COARSE_W   = COARSE_W_DEF,
  parameter int unsigned FINE_W     = FINE_W_DEF,
  parameter int unsigned EXP_W      = EXP_W_DEF,
  parameter int unsigned EXP_MAX    = EXP_MAX_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                standby,
  input  logic [COARSE_W-1:0] coarse,
  input  logic [FINE_W-1:0]   fine,
  input  logic [EXP_W-1:0]    expo,
  input  logic                bypass3,
  output logic                out_pulse,
  output logic                out_sq
);
  logic             idle, clr;
  logic             base_tick, bin_tick, div_tick, bypass_act;
  logic [EXP_W-1:0] expo_act;

  assign idle = (coarse == '0) && (fine == '0) && (expo == '0);
  assign clr  = rst || standby || idle;

  fsyn_phase_acc #(
    .BASE_TICKS(BASE_TICKS), .COARSE_W(COARSE_W), .FINE_W(FINE_W),
    .EXP_W(EXP_W), .EXP_MAX(EXP_MAX)
  ) u_acc (
    .clk(clk), .clr(clr), .coarse(coarse), .fine(fine), .expo(expo),
    .bypass3(bypass3), .base_tick(base_tick), .expo_act(expo_act),
    .bypass_act(bypass_act)
  );

  fsyn_bin_div #(.EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_bin (
    .clk(clk), .clr(clr), .tick_in(base_tick), .expo(expo_act), .tick_out(bin_tick)
  );

  fsyn_div3 u_div3 (
    .clk(clk), .clr(clr), .tick_in(bin_tick), .bypass(bypass_act), .tick_out(div_tick)
  );

  always_ff @(posedge clk) begin
    if (clr) begin
      out_pulse <= 1'b0;
      out_sq    <= 1'b0;
    end else begin
      out_pulse <= div_tick;
      if (div_tick) out_sq <= !out_sq;
    end
  end
endmodule

// File: rtl/fsyn_channel_checker.sv
module fsyn_channel_checker #(
  parameter int unsigned COARSE_W = 5,
  parameter int unsigned FINE_W   = 15,
  parameter int unsigned EXP_W    = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                standby,
  input logic [COARSE_W-1:0] coarse,
  input logic [FINE_W-1:0]   fine,
  input logic [EXP_W-1:0]    expo,
  input logic                out_pulse,
  input logic                out_sq
);
  logic [15:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (out_pulse) begin
      gap_q  <= 16'd1;
      seen_q <= 1'b1;
    end else if (gap_q != 16'hFFFF) begin
      gap_q <= gap_q + 16'd1;
    end
  end

  // R1: output pulses never closer than one minimum base period
  assert_min_gap_R1: assert property (@(posedge clk) disable iff (rst)
    (out_pulse && seen_q) |-> (gap_q >= 16'd32));

  // R6: standby silences the outputs from the next tick
  assert_standby_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    standby |=> (!out_pulse && !out_sq));

  // R8: all-zero setting yields no pulse
  assert_unprog_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (coarse == '0 && fine == '0 && expo == '0) |=> !out_pulse);

  // R9: pulse lasts a single tick
  assert_single_tick_R9: assert property (@(posedge clk) disable iff (rst)
    out_pulse |=> !out_pulse);

  // R9: square output toggles with every pulse
  assert_sq_toggle_R9: assert property (@(posedge clk) disable iff (rst)
    out_pulse |-> (out_sq != $past(out_sq)));
endmodule

bind fsyn_channel fsyn_channel_checker #(
  .COARSE_W(COARSE_W), .FINE_W(FINE_W), .EXP_W(EXP_W)
) u_fsyn_chk (
  .clk(clk), .rst(rst), .standby(standby), .coarse(coarse), .fine(fine),
  .expo(expo), .out_pulse(out_pulse), .out_sq(out_sq)
);

// File: tb/fsyn_channel_bench.sv
module fsyn_channel_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        standby = 1'b0;
  logic [4:0]  coarse = '0;
  logic [14:0] fine = '0;
  logic [3:0]  expo = '0;
  logic        bypass3 = 1'b1;
  logic        out_pulse, out_sq;

  int unsigned checks = 0;
  int unsigned errors = 0;
  longint unsigned cyc = 0;
  bit          timed_out = 1'b0;
  logic        prev_pulse = 1'b0;
  int unsigned pcount = 0;

  fsyn_channel u_fsyn_channel (
    .clk(clk), .rst(rst), .standby(standby), .coarse(coarse), .fine(fine),
    .expo(expo), .bypass3(bypass3), .out_pulse(out_pulse), .out_sq(out_sq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) if (cyc > 190000 && !timed_out) timed_out <= 1'b1;

  function automatic longint unsigned div_of(input int e, input bit b);
    int ee;
    ee = (e > 8) ? 8 : e;
    return (longint'(1) << ee) * (b ? 1 : 3);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R9: pulse width and square-wave parity, checked on every pulse
  always @(negedge clk) begin
    if (rst || standby) pcount = 0;
    else if (out_pulse) begin
      check(!prev_pulse, "R9 pulse width", 2, 1);
      pcount++;
      check(out_sq == pcount[0], "R9 square toggle", out_sq, pcount[0]);
    end
    prev_pulse = out_pulse;
  end

  task automatic wait_pulse(output longint unsigned t);
    t = 0;
    while (!timed_out) begin
      @(negedge clk);
      if (out_pulse) begin
        t = cyc;
        return;
      end
    end
  endtask

  task automatic setup(input int c, input int f, input int e, input bit b);
    @(negedge clk);
    rst = 1'b1; standby = 1'b0;
    coarse = 5'(c); fine = 15'(f); expo = 4'(e); bypass3 = b;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // R4: average over k output periods within one tick of the formula
  task automatic rate_case(input int c, input int f, input int e, input bit b,
                           input int k, input string req);
    longint unsigned t0, t1, n;
    longint signed   lhs, rhs, diff;
    setup(c, f, e, b);
    wait_pulse(t0);
    for (int i = 0; i < k; i++) wait_pulse(t1);
    n    = longint'(k) * div_of(e, b);
    lhs  = longint'(t1 - t0) * 32768;
    rhs  = longint'(n) * (longint'(32 + c) * 32768 + f);
    diff = lhs - rhs;
    if (diff < 0) diff = -diff;
    check(diff <= 32768, req, t1 - t0, rhs / 32768);
  endtask

  initial begin
    longint unsigned ta, tb, tc;
    void'($urandom(32'd1234));

    // R7: outputs low in reset
    repeat (3) @(negedge clk);
    check(!out_pulse && !out_sq, "R7 reset outputs", {out_pulse, out_sq}, 0);

    // R1/R7: exact base period with fine=0 and first period from clean state
    setup(31, 0, 0, 1'b1);
    wait_pulse(ta); wait_pulse(tb);
    check(tb - ta == 63, "R1 integer period", tb - ta, 63);
    // R1: fine = half, after reset periods go 32 then 33
    setup(0, 16384, 0, 1'b1);
    wait_pulse(ta); wait_pulse(tb); wait_pulse(tc);
    check(tb - ta == 33, "R1 carry tick", tb - ta, 33);
    check(tc - tb == 32, "R1 no-carry tick", tc - tb, 32);
    rate_case(0, 32767, 0, 1'b1, 40, "R1 max fine");

    // R2 / R3: post dividers
    rate_case(5, 0, 3, 1'b1, 2, "R2 binary divide");
    setup(0, 0, 12, 1'b1);
    wait_pulse(ta); wait_pulse(tb);
    check(tb - ta == 8192, "R2 exponent clamp", tb - ta, 8192);
    rate_case(7, 0, 0, 1'b0, 3, "R3 divide by 3");
    setup(0, 1, 8, 1'b0);
    wait_pulse(ta); wait_pulse(tb);
    check(tb - ta == 24576, "R2 R3 largest divide", tb - ta, 24576);

    // R4: random settings
    for (int i = 0; i < 14; i++) begin
      int c, f, e; bit b;
      c = int'($urandom_range(31, 0));
      f = int'($urandom_range(32767, 0));
      e = int'($urandom_range(2, 0));
      b = 1'($urandom_range(1, 0));
      if (c == 0 && f == 0 && e == 0) f = 1;
      rate_case(c, f, e, b, 3, "R4 random rate");
    end

    // R5: change in mid-period applies from next boundary
    setup(10, 0, 0, 1'b1);
    wait_pulse(ta);
    repeat (3) @(negedge clk);
    coarse = 5'd20;
    wait_pulse(tb); wait_pulse(tc);
    check(tb - ta == 42, "R5 old period kept", tb - ta, 42);
    check(tc - tb == 52, "R5 new period used", tc - tb, 52);

    // R6: standby silences outputs, then resumes
    begin
      bit quiet;
      quiet = 1'b1;
      standby = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (out_pulse || out_sq) quiet = 1'b0;
      end
      check(quiet, "R6 standby quiet", !quiet, 0);
      standby = 1'b0;
      wait_pulse(ta); wait_pulse(tb);
      check(tb - ta == 52, "R6 resume period", tb - ta, 52);
    end

    // R8: all-zero setting produces nothing
    begin
      bit quiet;
      quiet = 1'b1;
      setup(0, 0, 0, 1'b1);
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (out_pulse) quiet = 1'b0;
      end
      check(quiet, "R8 unprogrammed", !quiet, 0);
    end

    if (timed_out) check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule